// File: doc/BRIEF.md
# SD Card Data Path Transfer Sequencer

This block sequences the data phase of an SD/MMC host controller. Once software has programmed a byte count, block size, direction, transfer mode and timeout periods, a start request moves the sequencer out of its idle state. It then walks the card through block or stream transfers, one byte at a time, as the line serializer reports each byte moved. It keeps the count of bytes still to move. It arms a data timeout only in the states where the card is expected to answer, and a separate acknowledge timeout only while waiting for a boot acknowledge. It reports block completion, transfer completion, hold entry, timeouts and aborts as single-cycle pulses.

The programmed length is trimmed before use. In block mode it is cut down to whole blocks. In double-data-rate mode it is also cut down to an even count. An effective length of zero starts nothing. A hold input parks the sequencer in its wait states, and an abort input returns it to idle from anywhere. CRC, line serialization and FIFO storage belong to neighbouring blocks.

States, with their `state_o` code: IDLE (0), WAIT_S (1, ready to send a block), SEND (2), BUSY (3, card programming after a sent block), WAIT_R (4, waiting for a start bit), RECV (5), READ_WAIT (6), WAIT_ACK (7). The transitions are:
- IDLE to WAIT_ACK, WAIT_R or WAIT_S on start.
- WAIT_ACK to WAIT_R on acknowledge.
- WAIT_S to SEND when not held.
- SEND to BUSY at a block boundary.
- BUSY to WAIT_S, or to IDLE when finished, once the card leaves busy.
- WAIT_R to RECV on a start bit when not held.
- WAIT_R to READ_WAIT on a read-wait request, and back to WAIT_R when the request drops.
- RECV to WAIT_R, or to IDLE when finished, at a block boundary.
- Any non-idle state to IDLE on abort or on a timeout.

Top module: `sd_dpath_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (IDLE), and `active_o`, `en_o`, `remaining_o` and all pulse outputs are 0.
- R2: `start_i` in IDLE sets `en_o`. On the next edge, if the effective length is non-zero, the state becomes WAIT_ACK (7) when `cfg_ack_en`=1, otherwise WAIT_R (4) when `cfg_dir`=1 or WAIT_S (1) when `cfg_dir`=0, and `remaining_o` loads the effective length. `active_o` is 1 in every state except IDLE.
- R3: The effective length is derived from the programmed length in two steps. With `cfg_stream`=0 (block mode) it is rounded down to a multiple of 2^`cfg_blk_code` bytes; with `cfg_stream`=1 no block rounding applies. When `cfg_ddr`=1, bit 0 of the result is then cleared.
- R4: A start with an effective length of zero leaves the state at IDLE, clears `en_o` and raises no pulse.
- R5: Each `byte_ack_i` seen in SEND or RECV decrements `remaining_o` by one. In every other state `byte_ack_i` leaves `remaining_o` unchanged.
- R6: In block mode `blk_end_o` pulses once per completed block. A sent block moves to BUSY, which exits once `card_busy_i` is 0 (to WAIT_S, or to IDLE when no bytes remain). A received block returns to WAIT_R. Stream mode raises no `blk_end_o`.
- R7: When no bytes remain, the sequencer enters IDLE, pulses `data_end_o` and clears `en_o`.
- R8: While `hold_i`=1 the state stays in WAIT_S, or stays in WAIT_R instead of moving to RECV. Entering such a held wait pulses `hold_o` once.
- R9: The data timeout loads `cfg_tmo` on entry to WAIT_R or BUSY and counts `card_tick_i` pulses only in those states. On the tick that brings it to zero the sequencer enters IDLE, pulses `dtmo_o` alone (no `data_end_o`) and clears `en_o`.
- R10: In WAIT_ACK, `ack_ok_i` moves to WAIT_R. Otherwise the acknowledge timeout, loaded with `cfg_ack_tmo` on entry, ends in IDLE with an `ack_tmo_o` pulse on the tick that brings it to zero.
- R11: In WAIT_R, `rw_req_i`=1 moves to READ_WAIT (6). Its release moves back to WAIT_R with the data timeout reloaded. Ticks spent in READ_WAIT never time out.
- R12: `abort_i` in any non-idle state enters IDLE on the next edge, pulses `abort_o` and clears `en_o`.
- R13: `cfg_we` and `start_i` are ignored while `active_o`=1. A later start uses the configuration held before the transfer began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe (idle only) |
| cfg_dir | input | 1 | 1 = card to host, 0 = host to card |
| cfg_stream | input | 1 | 1 = stream mode, 0 = block mode |
| cfg_ddr | input | 1 | Double-data-rate: force even length |
| cfg_blk_code | input | 4 | Block size code N, block = 2^N bytes |
| cfg_len | input | 25 | Programmed byte length |
| cfg_tmo | input | 32 | Data timeout in card clock ticks |
| cfg_ack_en | input | 1 | Wait for boot acknowledge first |
| cfg_ack_tmo | input | 25 | Acknowledge timeout in card clock ticks |
| start_i | input | 1 | Start request (sets enable) |
| hold_i | input | 1 | Hold progress in wait states |
| abort_i | input | 1 | Abort request |
| byte_ack_i | input | 1 | One byte moved by the serializer |
| rx_start_i | input | 1 | Start bit seen on the data lines |
| card_busy_i | input | 1 | Card signals busy after a written block |
| rw_req_i | input | 1 | Read-wait request |
| ack_ok_i | input | 1 | Boot acknowledge received |
| card_tick_i | input | 1 | One pulse per card clock period |
| state_o | output | 3 | Current state code |
| active_o | output | 1 | Sequencer not idle |
| remaining_o | output | 25 | Bytes still to transfer |
| en_o | output | 1 | Transfer enable bit |
| blk_end_o | output | 1 | Block completed pulse |
| data_end_o | output | 1 | Transfer completed pulse |
| hold_o | output | 1 | Held wait entered pulse |
| dtmo_o | output | 1 | Data timeout pulse |
| ack_tmo_o | output | 1 | Acknowledge timeout pulse |
| abort_o | output | 1 | Transfer aborted pulse |

## Verification
The bench drives a table of lengths, block codes, directions, modes and double-data-rate settings. The table includes lengths that are not block multiples, odd lengths in double-data-rate mode, and cases where trimming leaves zero. A design that trims in the wrong order or ignores a mode would move the wrong number of bytes or count the wrong number of blocks. Timeout tests stop one tick short of expiry and then reach it, so an off-by-one counter shows as an early or missing `dtmo_o`. Ticks are also applied during READ_WAIT and a byte acknowledge is applied during WAIT_R, so a counter that runs in the wrong state is caught. The hold case includes a configuration write and a second start made while the sequencer is active; a lock that leaks would reload the new length.

// File: rtl/sd_dpath_pkg.sv
package sd_dpath_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_S   = 3'd1,
        ST_SEND     = 3'd2,
        ST_BUSY     = 3'd3,
        ST_WAIT_R   = 3'd4,
        ST_RECV     = 3'd5,
        ST_RD_WAIT  = 3'd6,
        ST_WAIT_ACK = 3'd7
    } dp_state_e;

endpackage

// File: rtl/sd_dpath_cfg.sv
module sd_dpath_cfg #(
    parameter int LEN_W = 25,
    parameter int TMO_W = 32,
    parameter int ACK_W = 25,
    parameter int BSZ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             active,
    input  logic             cfg_dir,
    input  logic             cfg_stream,
    input  logic             cfg_ddr,
    input  logic [BSZ_W-1:0] cfg_blk_code,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             cfg_ack_en,
    input  logic [ACK_W-1:0] cfg_ack_tmo,
    input  logic             start_i,
    input  logic             en_clr,
    output logic             dir_q,
    output logic             stream_q,
    output logic             ack_en_q,
    output logic [TMO_W-1:0] tmo_q,
    output logic [ACK_W-1:0] ack_tmo_q,
    output logic [LEN_W-1:0] eff_len,
    output logic [LEN_W-1:0] blk_mask,
    output logic             en_q
);

    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    logic             ddr_q;
    logic [BSZ_W-1:0] blk_code_q;
    logic [LEN_W-1:0] len_q;

    // Shadow registers: writable only while the sequencer is idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= 1'b0;
            stream_q   <= 1'b0;
            ddr_q      <= 1'b0;
            blk_code_q <= '0;
            len_q      <= '0;
            tmo_q      <= '0;
            ack_en_q   <= 1'b0;
            ack_tmo_q  <= '0;
        end else if (cfg_we && !active) begin
            dir_q      <= cfg_dir;
            stream_q   <= cfg_stream;
            ddr_q      <= cfg_ddr;
            blk_code_q <= cfg_blk_code;
            len_q      <= cfg_len;
            tmo_q      <= cfg_tmo;
            ack_en_q   <= cfg_ack_en;
            ack_tmo_q  <= cfg_ack_tmo;
        end
    end

    // Enable bit: set by a start while idle, cleared by the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_clr)
            en_q <= 1'b0;
        else if (start_i && !active)
            en_q <= 1'b1;
    end

    // Effective length: whole blocks first, then even count in DDR
    always_comb begin
        blk_mask = (ONE_L << blk_code_q) - ONE_L;
        eff_len  = stream_q ? len_q : (len_q & ~blk_mask);
        if (ddr_q)
            eff_len[0] = 1'b0;
    end

endmodule

// File: rtl/sd_dpath_timer.sv
module sd_dpath_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    // Expiry on the tick that takes the count to zero (or finds it there)
    assign expire = run && tick && (cnt_q <= W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && tick && (cnt_q != '0))
            cnt_q <= cnt_q - W'(1);
    end

endmodule

// File: rtl/sd_dpath_fsm.sv
module sd_dpath_fsm
    import sd_dpath_pkg::*;
#(
    parameter int LEN_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic [LEN_W-1:0] eff_len,
    input  logic [LEN_W-1:0] blk_mask,
    input  logic             dir_q,
    input  logic             stream_q,
    input  logic             ack_en_q,
    input  logic             hold_i,
    input  logic             abort_i,
    input  logic             byte_ack_i,
    input  logic             rx_start_i,
    input  logic             card_busy_i,
    input  logic             rw_req_i,
    input  logic             ack_ok_i,
    input  logic             dtmo_exp,
    input  logic             ack_exp,
    output dp_state_e        state_q,
    output logic [LEN_W-1:0] remaining_q,
    output logic             en_clr,
    output logic             dtmo_load,
    output logic             dtmo_run,
    output logic             ack_load,
    output logic             ack_run,
    output logic             blk_end_q,
    output logic             data_end_q,
    output logic             hold_q,
    output logic             dtmo_q,
    output logic             ack_tmo_q,
    output logic             abort_q
);

    dp_state_e        state_d;
    logic [LEN_W-1:0] rem_m1;
    logic             boundary;
    logic             load_rem, dec_rem;
    logic             ev_blk, ev_end, ev_dtmo, ev_ack, ev_abort;
    logic             held_d, held_q;

    assign rem_m1   = remaining_q - LEN_W'(1);
    assign boundary = stream_q ? (rem_m1 == '0) : ((rem_m1 & blk_mask) == '0);

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        en_clr   = 1'b0;
        load_rem = 1'b0;
        dec_rem  = 1'b0;
        ev_blk   = 1'b0;
        ev_end   = 1'b0;
        ev_dtmo  = 1'b0;
        ev_ack   = 1'b0;
        ev_abort = 1'b0;
        if (abort_i && (state_q != ST_IDLE)) begin
            state_d  = ST_IDLE;
            ev_abort = 1'b1;
            en_clr   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (en_q) begin
                        if (eff_len == '0) begin
                            en_clr = 1'b1;
                        end else begin
                            load_rem = 1'b1;
                            if (ack_en_q)
                                state_d = ST_WAIT_ACK;
                            else
                                state_d = dir_q ? ST_WAIT_R : ST_WAIT_S;
                        end
                    end
                end
                ST_WAIT_ACK: begin
                    if (ack_exp) begin
                        state_d = ST_IDLE;
                        ev_ack  = 1'b1;
                        en_clr  = 1'b1;
                    end else if (ack_ok_i) begin
                        state_d = ST_WAIT_R;
                    end
                end
                ST_WAIT_S: begin
                    if (!hold_i)
                        state_d = ST_SEND;
                end
                ST_SEND: begin
                    if (byte_ack_i) begin
                        dec_rem = 1'b1;
                        if (boundary) begin
                            state_d = ST_BUSY;
                            ev_blk  = !stream_q;
                        end
                    end
                end
                ST_BUSY: begin
                    if (dtmo_exp) begin
                        state_d = ST_IDLE;
                        ev_dtmo = 1'b1;
                        en_clr  = 1'b1;
                    end else if (!card_busy_i) begin
                        if (remaining_q == '0) begin
                            state_d = ST_IDLE;
                            ev_end  = 1'b1;
                            en_clr  = 1'b1;
                        end else begin
                            state_d = ST_WAIT_S;
                        end
                    end
                end
                ST_WAIT_R: begin
                    if (dtmo_exp) begin
                        state_d = ST_IDLE;
                        ev_dtmo = 1'b1;
                        en_clr  = 1'b1;
                    end else if (rw_req_i) begin
                        state_d = ST_RD_WAIT;
                    end else if (rx_start_i && !hold_i) begin
                        state_d = ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (byte_ack_i) begin
                        dec_rem = 1'b1;
                        if (boundary) begin
                            ev_blk = !stream_q;
                            if (rem_m1 == '0) begin
                                state_d = ST_IDLE;
                                ev_end  = 1'b1;
                                en_clr  = 1'b1;
                            end else begin
                                state_d = ST_WAIT_R;
                            end
                        end
                    end
                end
                ST_RD_WAIT: begin
                    if (!rw_req_i)
                        state_d = ST_WAIT_R;
                end
            endcase
        end
    end

    // Timer control: load on entry to the counting state, run while in it
    assign dtmo_load = (state_d != state_q) && ((state_d == ST_WAIT_R) || (state_d == ST_BUSY));
    assign dtmo_run  = (state_q == ST_WAIT_R) || (state_q == ST_BUSY);
    assign ack_load  = (state_d == ST_WAIT_ACK) && (state_q != ST_WAIT_ACK);
    assign ack_run   = (state_q == ST_WAIT_ACK);
    assign held_d    = hold_i && ((state_d == ST_WAIT_S) || (state_d == ST_WAIT_R));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs: byte counter and status pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining_q <= '0;
            held_q      <= 1'b0;
            blk_end_q   <= 1'b0;
            data_end_q  <= 1'b0;
            hold_q      <= 1'b0;
            dtmo_q      <= 1'b0;
            ack_tmo_q   <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            if (load_rem)
                remaining_q <= eff_len;
            else if (dec_rem)
                remaining_q <= rem_m1;
            held_q     <= held_d;
            blk_end_q  <= ev_blk;
            data_end_q <= ev_end;
            hold_q     <= held_d && !held_q;
            dtmo_q     <= ev_dtmo;
            ack_tmo_q  <= ev_ack;
            abort_q    <= ev_abort;
        end
    end

endmodule

// File: rtl/sd_dpath_ctrl.sv
module sd_dpath_ctrl
    import sd_dpath_pkg::*;
#(
    parameter int LEN_W = 25,
    parameter int TMO_W = 32,
    parameter int ACK_W = 25,
    parameter int BSZ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_dir,
    input  logic             cfg_stream,
    input  logic             cfg_ddr,
    input  logic [BSZ_W-1:0] cfg_blk_code,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [TMO_W-1:0] cfg_tmo,
    input  logic             cfg_ack_en,
    input  logic [ACK_W-1:0] cfg_ack_tmo,
    input  logic             start_i,
    input  logic             hold_i,
    input  logic             abort_i,
    input  logic             byte_ack_i,
    input  logic             rx_start_i,
    input  logic             card_busy_i,
    input  logic             rw_req_i,
    input  logic             ack_ok_i,
    input  logic             card_tick_i,
    output logic [2:0]       state_o,
    output logic             active_o,
    output logic [LEN_W-1:0] remaining_o,
    output logic             en_o,
    output logic             blk_end_o,
    output logic             data_end_o,
    output logic             hold_o,
    output logic             dtmo_o,
    output logic             ack_tmo_o,
    output logic             abort_o
);

    dp_state_e        state_q;
    logic             dir_q, stream_q, ack_en_q, en_q, en_clr;
    logic [TMO_W-1:0] tmo_q;
    logic [ACK_W-1:0] ack_tmo_q;
    logic [LEN_W-1:0] eff_len, blk_mask;
    logic             dtmo_load, dtmo_run, dtmo_exp;
    logic             ack_load, ack_run, ack_exp;

    assign state_o  = state_q;
    assign active_o = (state_q != ST_IDLE);
    assign en_o     = en_q;

    sd_dpath_cfg #(.LEN_W(LEN_W), .TMO_W(TMO_W), .ACK_W(ACK_W), .BSZ_W(BSZ_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .active(active_o),
        .cfg_dir(cfg_dir), .cfg_stream(cfg_stream), .cfg_ddr(cfg_ddr),
        .cfg_blk_code(cfg_blk_code), .cfg_len(cfg_len), .cfg_tmo(cfg_tmo),
        .cfg_ack_en(cfg_ack_en), .cfg_ack_tmo(cfg_ack_tmo),
        .start_i(start_i), .en_clr(en_clr),
        .dir_q(dir_q), .stream_q(stream_q), .ack_en_q(ack_en_q),
        .tmo_q(tmo_q), .ack_tmo_q(ack_tmo_q),
        .eff_len(eff_len), .blk_mask(blk_mask), .en_q(en_q)
    );

    sd_dpath_timer #(.W(TMO_W)) u_dtmo (
        .clk(clk), .rst_n(rst_n), .load(dtmo_load), .load_val(tmo_q),
        .run(dtmo_run), .tick(card_tick_i), .expire(dtmo_exp)
    );

    sd_dpath_timer #(.W(ACK_W)) u_acktmo (
        .clk(clk), .rst_n(rst_n), .load(ack_load), .load_val(ack_tmo_q),
        .run(ack_run), .tick(card_tick_i), .expire(ack_exp)
    );

    sd_dpath_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_q(en_q), .eff_len(eff_len),
        .blk_mask(blk_mask), .dir_q(dir_q), .stream_q(stream_q),
        .ack_en_q(ack_en_q), .hold_i(hold_i), .abort_i(abort_i),
        .byte_ack_i(byte_ack_i), .rx_start_i(rx_start_i),
        .card_busy_i(card_busy_i), .rw_req_i(rw_req_i), .ack_ok_i(ack_ok_i),
        .dtmo_exp(dtmo_exp), .ack_exp(ack_exp),
        .state_q(state_q), .remaining_q(remaining_o), .en_clr(en_clr),
        .dtmo_load(dtmo_load), .dtmo_run(dtmo_run),
        .ack_load(ack_load), .ack_run(ack_run),
        .blk_end_q(blk_end_o), .data_end_q(data_end_o), .hold_q(hold_o),
        .dtmo_q(dtmo_o), .ack_tmo_q(ack_tmo_o), .abort_q(abort_o)
    );

endmodule

// File: rtl/sd_dpath_chk.sv
module sd_dpath_chk #(
    parameter int LEN_W = 25
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       state_o,
    input logic [LEN_W-1:0] remaining_o,
    input logic             en_o,
    input logic             hold_i,
    input logic             abort_i,
    input logic             byte_ack_i,
    input logic             data_end_o,
    input logic             dtmo_o,
    input logic             ack_tmo_o,
    input logic             abort_o
);

    logic xfer_st, wait_st;
    assign xfer_st = (state_o == 3'd2) || (state_o == 3'd5);
    assign wait_st = (state_o == 3'd1) || (state_o == 3'd3) || (state_o == 3'd4)
                   || (state_o == 3'd6) || (state_o == 3'd7);

    AST_BYTE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_st && byte_ack_i && !abort_i |=> remaining_o == $past(remaining_o) - LEN_W'(1)); // R5
    AST_WAIT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st |=> $stable(remaining_o)); // R5
    AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1) && hold_i && !abort_i |=> state_o == 3'd1); // R8
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd0) && abort_i |=> (state_o == 3'd0) && abort_o && !en_o); // R12
    AST_END_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        data_end_o |-> (state_o == 3'd0) && (remaining_o == '0) && !en_o); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_end_o, dtmo_o, ack_tmo_o, abort_o})); // R9

endmodule

bind sd_dpath_ctrl sd_dpath_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_o(state_o), .remaining_o(remaining_o),
    .en_o(en_o), .hold_i(hold_i), .abort_i(abort_i), .byte_ack_i(byte_ack_i),
    .data_end_o(data_end_o), .dtmo_o(dtmo_o), .ack_tmo_o(ack_tmo_o),
    .abort_o(abort_o)
);

// File: tb/sim_sd_dpath_ctrl.sv
`timescale 1ns/1ps
module sim_sd_dpath_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0, cfg_dir = 0, cfg_stream = 0, cfg_ddr = 0, cfg_ack_en = 0;
    logic [3:0]  cfg_blk_code = '0;
    logic [24:0] cfg_len = '0, cfg_ack_tmo = '0;
    logic [31:0] cfg_tmo = '0;
    logic        start_i = 0, hold_i = 0, abort_i = 0, byte_ack_i = 0, rx_start_i = 0;
    logic        card_busy_i = 0, rw_req_i = 0, ack_ok_i = 0, card_tick_i = 0;
    logic [2:0]  state_o;
    logic        active_o, en_o, blk_end_o, data_end_o, hold_o, dtmo_o, ack_tmo_o, abort_o;
    logic [24:0] remaining_o;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #2.5 clk = ~clk;

    sd_dpath_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir(cfg_dir),
        .cfg_stream(cfg_stream), .cfg_ddr(cfg_ddr), .cfg_blk_code(cfg_blk_code),
        .cfg_len(cfg_len), .cfg_tmo(cfg_tmo), .cfg_ack_en(cfg_ack_en),
        .cfg_ack_tmo(cfg_ack_tmo), .start_i(start_i), .hold_i(hold_i),
        .abort_i(abort_i), .byte_ack_i(byte_ack_i), .rx_start_i(rx_start_i),
        .card_busy_i(card_busy_i), .rw_req_i(rw_req_i), .ack_ok_i(ack_ok_i),
        .card_tick_i(card_tick_i), .state_o(state_o), .active_o(active_o),
        .remaining_o(remaining_o), .en_o(en_o), .blk_end_o(blk_end_o),
        .data_end_o(data_end_o), .hold_o(hold_o), .dtmo_o(dtmo_o),
        .ack_tmo_o(ack_tmo_o), .abort_o(abort_o)
    );

    typedef struct packed {
        logic        dir;
        logic        strm;
        logic        ddr;
        logic [3:0]  code;
        logic [24:0] len;
        logic [24:0] eff;
        logic [7:0]  blks;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 4'd2, 25'd10, 25'd8,  8'd2},
        '{1'b1, 1'b0, 1'b0, 4'd3, 25'd20, 25'd16, 8'd2},
        '{1'b1, 1'b1, 1'b0, 4'd0, 25'd5,  25'd5,  8'd0},
        '{1'b0, 1'b1, 1'b1, 4'd0, 25'd7,  25'd6,  8'd0},
        '{1'b1, 1'b0, 1'b1, 4'd1, 25'd7,  25'd6,  8'd3},
        '{1'b0, 1'b0, 1'b0, 4'd4, 25'd10, 25'd0,  8'd0},
        '{1'b1, 1'b0, 1'b0, 4'd0, 25'd3,  25'd3,  8'd3},
        '{1'b0, 1'b0, 1'b1, 4'd0, 25'd1,  25'd0,  8'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary_and_finish();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary_and_finish();
        end
    end

    task automatic cfg_write(input logic dir, input logic strm, input logic ddr,
                             input logic [3:0] code, input logic [24:0] len,
                             input logic [31:0] tmo, input logic acken,
                             input logic [24:0] acktmo);
        cfg_dir = dir; cfg_stream = strm; cfg_ddr = ddr; cfg_blk_code = code;
        cfg_len = len; cfg_tmo = tmo; cfg_ack_en = acken; cfg_ack_tmo = acktmo;
        cfg_we = 1'b1;
        step();
        cfg_we = 1'b0;
    endtask

    // Pulse start, then wait until the state has had its edge to leave idle
    task automatic start_xfer();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        step();
    endtask

    // Serve the transfer until idle, counting bytes, block pulses and end pulses
    task automatic run_to_idle(output int nb, output int nblk, output int nend);
        bit done = 0;
        nb = 0; nblk = 0; nend = 0;
        for (int k = 0; k < 600 && !done; k++) begin
            if (blk_end_o) nblk++;
            if (data_end_o) nend++;
            if (state_o == 3'd0) done = 1;
            byte_ack_i = (state_o == 3'd2) || (state_o == 3'd5);
            rx_start_i = (state_o == 3'd4);
            if (byte_ack_i) nb++;
            if (!done) step();
        end
        byte_ack_i = 1'b0;
        rx_start_i = 1'b0;
    endtask

    initial begin
        int nb, nblk, nend;
        step();
        step();
        // R1: reset state
        chk(state_o == 3'd0, "R1", "state", state_o, 0);
        chk(!active_o && !en_o, "R1", "active/en", {active_o, en_o}, 0);
        chk(remaining_o == '0, "R1", "remaining", remaining_o, 0);
        chk({blk_end_o, data_end_o, hold_o, dtmo_o, ack_tmo_o, abort_o} == '0,
            "R1", "pulses", {blk_end_o, data_end_o, hold_o, dtmo_o, ack_tmo_o, abort_o}, 0);
        rst_n = 1'b1;
        step();

        // Vector table: R2, R3, R4, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            int exp_st = (t.eff == 0) ? 0 : (t.dir ? 4 : 1);
            cfg_write(t.dir, t.strm, t.ddr, t.code, t.len, 32'd1000, 1'b0, 25'd0);
            start_xfer();
            chk(state_o == 3'(exp_st), "R2", "state after start", state_o, exp_st);
            if (t.eff == 0) begin
                chk(!en_o && !active_o, "R4", "zero length en/active", {en_o, active_o}, 0);
                chk(!data_end_o && !abort_o, "R4", "zero length pulses",
                    {data_end_o, abort_o}, 0);
            end else begin
                chk(remaining_o == t.eff, "R3", "effective length", remaining_o, t.eff);
                chk(active_o, "R2", "active", active_o, 1);
                run_to_idle(nb, nblk, nend);
                chk(nb == int'(t.eff), "R5", "bytes moved", nb, t.eff);
                chk(nblk == int'(t.blks), "R6", "block pulses", nblk, t.blks);
                chk(nend == 1, "R7", "data end pulses", nend, 1);
                chk(!en_o && remaining_o == '0, "R7", "en/remaining at end",
                    remaining_o + (en_o ? 1 : 0), 0);
            end
            step();
        end

        // R8 + R13: held send, config write and start while active
        hold_i = 1'b1;
        cfg_write(1'b0, 1'b0, 1'b0, 4'd2, 25'd4, 32'd1000, 1'b0, 25'd0);
        start_xfer();
        chk(state_o == 3'd1 && hold_o, "R8", "held entry state/pulse", {state_o, hold_o}, 3);
        step();
        chk(state_o == 3'd1 && !hold_o, "R8", "still held, single pulse", {state_o, hold_o}, 2);
        cfg_write(1'b0, 1'b0, 1'b0, 4'd2, 25'd12, 32'd1000, 1'b0, 25'd0);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(state_o == 3'd1, "R8", "held across writes", state_o, 1);
        hold_i = 1'b0;
        step();
        chk(state_o == 3'd2, "R8", "release to SEND", state_o, 2);
        run_to_idle(nb, nblk, nend);
        chk(nb == 4, "R13", "bytes with locked config", nb, 4);
        step();
        start_xfer();
        chk(remaining_o == 25'd4, "R13", "write while active ignored", remaining_o, 4);
        abort_i = 1'b1;
        step();
        abort_i = 1'b0;
        chk(state_o == 3'd0 && abort_o && !en_o, "R12", "abort from WAIT_S",
            {state_o, abort_o, en_o}, 2);
        step();

        // R9 + R5: data timeout in WAIT_R, byte ack ignored while waiting
        cfg_write(1'b1, 1'b0, 1'b0, 4'd2, 25'd4, 32'd3, 1'b0, 25'd0);
        start_xfer();
        byte_ack_i = 1'b1;
        step();
        byte_ack_i = 1'b0;
        chk(remaining_o == 25'd4 && state_o == 3'd4, "R5", "ack ignored in WAIT_R",
            remaining_o, 4);
        for (int i = 0; i < 3; i++) begin
            card_tick_i = 1'b1;
            step();
            card_tick_i = 1'b0;
            if (i < 2)
                chk(state_o == 3'd4 && !dtmo_o, "R9", "before expiry", state_o, 4);
            else
                chk(state_o == 3'd0 && dtmo_o && !data_end_o && !en_o, "R9",
                    "timeout on third tick", {state_o, dtmo_o, data_end_o, en_o}, 4);
        end
        step();

        // R11: read wait freezes the timeout
        cfg_write(1'b1, 1'b0, 1'b0, 4'd2, 25'd4, 32'd2, 1'b0, 25'd0);
        start_xfer();
        rw_req_i = 1'b1;
        step();
        chk(state_o == 3'd6, "R11", "enter READ_WAIT", state_o, 6);
        card_tick_i = 1'b1;
        for (int i = 0; i < 4; i++) step();
        card_tick_i = 1'b0;
        chk(state_o == 3'd6 && !dtmo_o, "R11", "no timeout in READ_WAIT", state_o, 6);
        rw_req_i = 1'b0;
        step();
        chk(state_o == 3'd4, "R11", "back to WAIT_R", state_o, 4);
        card_tick_i = 1'b1;
        step();
        card_tick_i = 1'b0;
        chk(state_o == 3'd4, "R11", "timeout reloaded", state_o, 4);
        abort_i = 1'b1;
        step();
        abort_i = 1'b0;
        chk(state_o == 3'd0 && abort_o, "R12", "abort from WAIT_R", {state_o, abort_o}, 1);
        step();

        // R10: acknowledge timeout and acknowledge received
        cfg_write(1'b1, 1'b0, 1'b0, 4'd2, 25'd4, 32'd1000, 1'b1, 25'd2);
        start_xfer();
        chk(state_o == 3'd7 && active_o, "R10", "enter WAIT_ACK", state_o, 7);
        card_tick_i = 1'b1;
        step();
        chk(state_o == 3'd7, "R10", "one tick short", state_o, 7);
        step();
        card_tick_i = 1'b0;
        chk(state_o == 3'd0 && ack_tmo_o && !en_o, "R10", "ack timeout",
            {state_o, ack_tmo_o, en_o}, 2);
        step();
        start_xfer();
        ack_ok_i = 1'b1;
        step();
        ack_ok_i = 1'b0;
        chk(state_o == 3'd4, "R10", "ack received to WAIT_R", state_o, 4);
        run_to_idle(nb, nblk, nend);
        chk(nb == 4 && nend == 1, "R7", "transfer after ack", nb, 4);

        summary_and_finish();
    end

endmodule